// File: doc/BRIEF.md
# Multi-Step Custom Instruction Sequencer

This block steps a specialized functional unit through one custom instruction. A start pulse carries a 10-bit instruction identifier, an operand addressing mode, four register values and four immediate values. The sequencer latches them, then looks up that identifier in an on-block control store. Each store entry holds a step count of one to four and up to four 62-bit step words. For each step in turn, the sequencer presents that step's word to the fabric. The word carries a unit configuration field, the operand routing selects and two result-capture controls.

The fabric hands back two unit outputs every cycle. At the end of each step, the step word decides whether each of the two instruction results is taken from one of those unit outputs. A result may therefore be picked up at any step, and a later step may replace an earlier pick. The cycle after the final step carries a single-cycle done pulse together with the two results and their valid flags. The sequencer is idle again one cycle later. The control store is written through a simple write port that sets a step word per identifier and slot, or the step count per identifier.

Top module: `ci_step_sequencer`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `step_act`, `res0_vld` and `res1_vld` are 0 and `fu_cfg` and `fu_route` are 0.
- R2: A `start` sampled while idle is accepted. In the following cycle `busy` and `step_act` are 1, `step_idx` is 0, and `fu_cfg`/`fu_route` show bits [45:0]/[57:46] of slot 0 of the stored entry for the latched `cid`.
- R3: An entry whose stored length code is L (`cm_len`, meaning L+1 steps) runs exactly L+1 consecutive active cycles with `step_idx` 0,1,..,L. Each cycle shows the step word of the matching slot.
- R4: `done` is 1 for exactly one cycle, the cycle after the final step, with `step_act` 0 and `busy` 1; in the next cycle `busy` and `done` are 0.
- R5: Operand k is taken from `imm_val[k]` when k + `amode` >= 4, else from `rs_val[k]`. So mode 0 is all registers, 1 makes operand 3 immediate, 2 makes operands 2..3 immediate, and 3 makes operands 1..3 immediate. `opnd` is captured at the accepted start and held while busy.
- R6: In an active step, word bit 59 set captures `fu_y[bit58]` into `res0` at the end of that step, and bit 61 set captures `fu_y[bit60]` into `res1`. Each capture sets the matching valid flag, and a later capture overwrites an earlier one.
- R7: Both valid flags clear on an accepted start, so an instruction with no capture bits ends with both flags 0.
- R8: A `start` while busy (running or done) has no effect: identifier, operands, step sequence and results are those of the running instruction.
- R9: The control store keeps a separate entry for every identifier 0..1023. `cm_we` writes `cm_word` into slot `cm_slot` of entry `cm_cid`, and `cm_len_we` writes `cm_len` as that entry's length code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request |
| cid | input | 10 | Custom instruction identifier |
| amode | input | 2 | Operand addressing mode |
| rs_val | input | 4x32 | Register operand values |
| imm_val | input | 4x32 | Immediate operand values |
| cm_we | input | 1 | Control store step-word write |
| cm_len_we | input | 1 | Control store length write |
| cm_cid | input | 10 | Control store entry for writes |
| cm_slot | input | 2 | Step slot for word write |
| cm_word | input | 62 | Step word to write |
| cm_len | input | 2 | Length code (steps minus one) |
| fu_y | input | 2x32 | Unit outputs from the fabric |
| busy | output | 1 | Instruction in progress |
| step_act | output | 1 | A step word is being applied |
| step_idx | output | 2 | Current step number |
| fu_cfg | output | 46 | Unit configuration for this step |
| fu_route | output | 12 | Operand routing selects for this step |
| opnd | output | 4x32 | Latched operands |
| done | output | 1 | Completion pulse |
| res0 | output | 32 | First result |
| res1 | output | 32 | Second result |
| res0_vld | output | 1 | First result was captured |
| res1_vld | output | 1 | Second result was captured |

## Verification
The bench goes after one-step instructions, where done follows the launch after a single step; a sequencer that counted the length code as the step count would run one step short or one long. It drives a start in the middle of a run; a design that took it would jump to the new entry's words or swap operands. Programs that capture the same result at two steps expose a design that keeps the first pick. An all-idle program run right after a capturing one exposes flags not cleared on launch. Entries 0 and 1023 are both loaded to catch aliasing in the identifier decode.

// File: rtl/ci_seq_pkg.sv
package ci_seq_pkg;
    localparam int DATA_W    = 32;
    localparam int CID_W     = 10;
    localparam int MAX_STEPS = 4;
    localparam int STEP_W    = $clog2(MAX_STEPS);
    localparam int WORD_W    = 62;
    localparam int N_OPND    = 4;
    localparam int N_FU      = 2;
    localparam int N_RES     = 2;
    localparam int SEL_W     = 3;
    localparam int ROUTE_W   = N_FU * 2 * SEL_W;
    localparam int CFG_W     = WORD_W - 2 * N_RES - ROUTE_W;

    typedef struct packed {
        logic               cap1_en;
        logic               cap1_src;
        logic               cap0_en;
        logic               cap0_src;
        logic [ROUTE_W-1:0] route;
        logic [CFG_W-1:0]   fu_cfg;
    } step_word_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_t;

    // operand position idx is an immediate when idx + mode reaches N_OPND
    function automatic logic opnd_is_imm(input logic [1:0] mode, input int idx);
        return (idx + int'(mode)) >= N_OPND;
    endfunction
endpackage

// File: rtl/ci_ctrl_store.sv
module ci_ctrl_store
    import ci_seq_pkg::*;
#(
    parameter int ID_W = CID_W,
    localparam int N_ENT = 1 << ID_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic              len_we,
    input  logic [ID_W-1:0]   wcid,
    input  logic [STEP_W-1:0] wslot,
    input  logic [WORD_W-1:0] wword,
    input  logic [STEP_W-1:0] wlen,
    input  logic [ID_W-1:0]   rcid,
    input  logic [STEP_W-1:0] rslot,
    output logic [WORD_W-1:0] rword,
    output logic [STEP_W-1:0] rlen
);
    logic [WORD_W-1:0] words [N_ENT][MAX_STEPS];
    logic [STEP_W-1:0] lens  [N_ENT];

    always_ff @(posedge clk) begin
        if (we)     words[wcid][wslot] <= wword;
        if (len_we) lens[wcid]         <= wlen;
    end

    assign rword = words[rcid][rslot];
    assign rlen  = lens[rcid];
endmodule

// File: rtl/ci_seq_ctrl.sv
module ci_seq_ctrl
    import ci_seq_pkg::*;
#(
    parameter int ID_W = CID_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ID_W-1:0]   cid_in,
    input  logic [STEP_W-1:0] last_idx,
    output logic              busy,
    output logic              run,
    output logic              done,
    output logic              accept,
    output logic [STEP_W-1:0] step,
    output logic [ID_W-1:0]   cid_q
);
    seq_state_t state;

    assign accept = start && (state == ST_IDLE);
    assign run    = (state == ST_RUN);
    assign done   = (state == ST_DONE);
    assign busy   = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            step  <= '0;
            cid_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    state <= ST_RUN;
                    step  <= '0;
                    cid_q <= cid_in;
                end
                ST_RUN: begin
                    if (step == last_idx) state <= ST_DONE;
                    else                  step  <= step + 1'b1;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_FIRST_STEP: assert property (@(posedge clk) disable iff (rst)
        accept |=> (run && step == '0)) else $error("first step"); // R2
    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (run && step != last_idx) |=> (run && step == $past(step) + 1'b1)) else $error("step advance"); // R3
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (run && step == last_idx) |=> done) else $error("done after last"); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy)) else $error("done pulse"); // R4
    AST_CID_HELD: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cid_q)) else $error("cid held"); // R8
endmodule

// File: rtl/ci_opnd_latch.sv
module ci_opnd_latch
    import ci_seq_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NO = N_OPND
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               busy,
    input  logic [1:0]         mode,
    input  logic [NO-1:0][DW-1:0] rs,
    input  logic [NO-1:0][DW-1:0] imm,
    output logic [NO-1:0][DW-1:0] opnd
);
    for (genvar g = 0; g < NO; g++) begin : g_op
        always_ff @(posedge clk) begin
            if (rst)       opnd[g] <= '0;
            else if (load) opnd[g] <= opnd_is_imm(mode, g) ? imm[g] : rs[g];
        end
    end

    AST_OPND_HELD: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(opnd)) else $error("operands held"); // R5
endmodule

// File: rtl/ci_res_capture.sv
module ci_res_capture
    import ci_seq_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NR = N_RES,
    parameter int NF = N_FU
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 run,
    input  logic [NR-1:0]        cap_en,
    input  logic [NR-1:0]        cap_src,
    input  logic [NF-1:0][DW-1:0] fu_y,
    output logic [NR-1:0][DW-1:0] res,
    output logic [NR-1:0]        vld
);
    for (genvar g = 0; g < NR; g++) begin : g_res
        always_ff @(posedge clk) begin
            if (rst) begin
                res[g] <= '0;
                vld[g] <= 1'b0;
            end else if (clear) begin
                vld[g] <= 1'b0;
            end else if (run && cap_en[g]) begin
                res[g] <= fu_y[cap_src[g]];
                vld[g] <= 1'b1;
            end
        end
    end

    AST_VLD_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clear |=> (vld == '0)) else $error("valid clear"); // R7
    AST_RES_QUIET: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(res)) else $error("result quiet"); // R6
endmodule

// File: rtl/ci_step_sequencer.sv
module ci_step_sequencer
    import ci_seq_pkg::*;
#(
    parameter int DW   = DATA_W,
    parameter int ID_W = CID_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [ID_W-1:0]           cid,
    input  logic [1:0]                amode,
    input  logic [N_OPND-1:0][DW-1:0] rs_val,
    input  logic [N_OPND-1:0][DW-1:0] imm_val,
    input  logic                      cm_we,
    input  logic                      cm_len_we,
    input  logic [ID_W-1:0]           cm_cid,
    input  logic [STEP_W-1:0]         cm_slot,
    input  logic [WORD_W-1:0]         cm_word,
    input  logic [STEP_W-1:0]         cm_len,
    input  logic [N_FU-1:0][DW-1:0]   fu_y,
    output logic                      busy,
    output logic                      step_act,
    output logic [STEP_W-1:0]         step_idx,
    output logic [CFG_W-1:0]          fu_cfg,
    output logic [ROUTE_W-1:0]        fu_route,
    output logic [N_OPND-1:0][DW-1:0] opnd,
    output logic                      done,
    output logic [DW-1:0]             res0,
    output logic [DW-1:0]             res1,
    output logic                      res0_vld,
    output logic                      res1_vld
);
    logic              run, accept;
    logic [ID_W-1:0]   cid_q;
    logic [STEP_W-1:0] last_idx;
    logic [WORD_W-1:0] raw_word;
    step_word_t        sw;
    logic [N_RES-1:0][DW-1:0] res;
    logic [N_RES-1:0]  vld;

    ci_ctrl_store #(.ID_W(ID_W)) u_store (
        .clk(clk), .we(cm_we), .len_we(cm_len_we), .wcid(cm_cid),
        .wslot(cm_slot), .wword(cm_word), .wlen(cm_len),
        .rcid(cid_q), .rslot(step_idx), .rword(raw_word), .rlen(last_idx)
    );

    ci_seq_ctrl #(.ID_W(ID_W)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .cid_in(cid), .last_idx(last_idx),
        .busy(busy), .run(run), .done(done), .accept(accept),
        .step(step_idx), .cid_q(cid_q)
    );

    ci_opnd_latch #(.DW(DW), .NO(N_OPND)) u_opnd (
        .clk(clk), .rst(rst), .load(accept), .busy(busy), .mode(amode),
        .rs(rs_val), .imm(imm_val), .opnd(opnd)
    );

    assign sw       = step_word_t'(raw_word);
    assign step_act = run;
    assign fu_cfg   = run ? sw.fu_cfg : '0;
    assign fu_route = run ? sw.route  : '0;

    ci_res_capture #(.DW(DW), .NR(N_RES), .NF(N_FU)) u_res (
        .clk(clk), .rst(rst), .clear(accept), .run(run),
        .cap_en({sw.cap1_en, sw.cap0_en}), .cap_src({sw.cap1_src, sw.cap0_src}),
        .fu_y(fu_y), .res(res), .vld(vld)
    );

    assign res0     = res[0];
    assign res1     = res[1];
    assign res0_vld = vld[0];
    assign res1_vld = vld[1];

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (fu_cfg == '0 && fu_route == '0 && !done)) else $error("idle outputs"); // R1
endmodule

// File: tb/tb_ci_step_sequencer.sv
module tb_ci_step_sequencer;
    logic clk = 1'b0;
    logic rst;
    logic start;
    logic [9:0] cid;
    logic [1:0] amode;
    logic [3:0][31:0] rs_val, imm_val;
    logic cm_we, cm_len_we;
    logic [9:0] cm_cid;
    logic [1:0] cm_slot, cm_len;
    logic [61:0] cm_word;
    logic [1:0][31:0] fu_y;
    logic busy, step_act, done, res0_vld, res1_vld;
    logic [1:0] step_idx;
    logic [45:0] fu_cfg;
    logic [11:0] fu_route;
    logic [3:0][31:0] opnd;
    logic [31:0] res0, res1;

    int vectors = 0;
    int fails = 0;
    bit finished = 0;

    logic [61:0] pw [8][4];
    int          plen [8];
    logic [9:0]  pcid [8];

    always #4 clk = ~clk;

    ci_step_sequencer dut (
        .clk(clk), .rst(rst), .start(start), .cid(cid), .amode(amode),
        .rs_val(rs_val), .imm_val(imm_val), .cm_we(cm_we), .cm_len_we(cm_len_we),
        .cm_cid(cm_cid), .cm_slot(cm_slot), .cm_word(cm_word), .cm_len(cm_len),
        .fu_y(fu_y), .busy(busy), .step_act(step_act), .step_idx(step_idx),
        .fu_cfg(fu_cfg), .fu_route(fu_route), .opnd(opnd), .done(done),
        .res0(res0), .res1(res1), .res0_vld(res0_vld), .res1_vld(res1_vld)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [61:0] rand_word();
        logic [63:0] t = {$urandom(), $urandom()};
        return t[61:0];
    endfunction

    function automatic logic [31:0] exp_opnd(input logic [1:0] m, input int k,
                                             input logic [31:0] r, input logic [31:0] i);
        return (k + int'(m) >= 4) ? i : r;
    endfunction

    task automatic load_prog(input int p);
        @(negedge clk);
        cm_len_we = 1; cm_cid = pcid[p]; cm_len = 2'(plen[p]);
        @(negedge clk);
        cm_len_we = 0;
        for (int s = 0; s < 4; s++) begin
            cm_we = 1; cm_slot = 2'(s); cm_word = pw[p][s];
            @(negedge clk);
        end
        cm_we = 0;
    endtask

    task automatic run_ci(input int p, input logic [1:0] m, input bit poke);
        logic [3:0][31:0] r, i, eo;
        logic [31:0] e0, e1;
        logic v0, v1;
        v0 = 0; v1 = 0; e0 = res0; e1 = res1;
        for (int k = 0; k < 4; k++) begin
            r[k] = $urandom(); i[k] = $urandom();
            eo[k] = exp_opnd(m, k, r[k], i[k]);
        end
        @(negedge clk);
        start = 1; cid = pcid[p]; amode = m; rs_val = r; imm_val = i;
        @(negedge clk);
        start = 0;
        for (int s = 0; s <= plen[p]; s++) begin
            chk("R2 busy", 64'(busy), 64'd1);
            chk("R3 step_act", 64'(step_act), 64'd1);
            chk("R3 step_idx", 64'(step_idx), 64'(s));
            chk("R3 fu_cfg", 64'(fu_cfg), 64'(pw[p][s][45:0]));
            chk("R3 fu_route", 64'(fu_route), 64'(pw[p][s][57:46]));
            for (int k = 0; k < 4; k++) chk("R5 opnd", 64'(opnd[k]), 64'(eo[k]));
            if (poke && s == 0) begin
                start = 1; cid = pcid[(p + 1) % 8]; amode = ~m;
                rs_val = {$urandom(), $urandom(), $urandom(), $urandom()};
                imm_val = {$urandom(), $urandom(), $urandom(), $urandom()};
            end
            fu_y[0] = $urandom(); fu_y[1] = $urandom();
            if (pw[p][s][59]) begin e0 = fu_y[pw[p][s][58]]; v0 = 1; end
            if (pw[p][s][61]) begin e1 = fu_y[pw[p][s][60]]; v1 = 1; end
            @(negedge clk);
            start = 0;
        end
        chk("R4 done", 64'(done), 64'd1);
        chk("R4 step_act at done", 64'(step_act), 64'd0);
        chk("R4 busy at done", 64'(busy), 64'd1);
        chk("R6 R7 res0_vld", 64'(res0_vld), 64'(v0));
        chk("R6 R7 res1_vld", 64'(res1_vld), 64'(v1));
        if (v0) chk("R6 res0", 64'(res0), 64'(e0));
        if (v1) chk("R6 res1", 64'(res1), 64'(e1));
        @(negedge clk);
        chk("R4 done low", 64'(done), 64'd0);
        chk("R4 R8 idle", 64'(busy), 64'd0);
    endtask

    initial begin
        void'($urandom(32'd24681));
        rst = 1; start = 0; cid = 0; amode = 0; rs_val = '0; imm_val = '0;
        cm_we = 0; cm_len_we = 0; cm_cid = 0; cm_slot = 0; cm_word = '0; cm_len = 0;
        fu_y = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 done", 64'(done), 64'd0);
        chk("R1 step_act", 64'(step_act), 64'd0);
        chk("R1 vld", 64'({res0_vld, res1_vld}), 64'd0);
        chk("R1 fu_cfg", 64'({fu_cfg, fu_route}), 64'd0);

        // R9: extremes of the identifier range plus scattered entries
        for (int p = 0; p < 8; p++) begin
            pcid[p] = (p == 0) ? 10'd0 : (p == 1) ? 10'd1023 : 10'(128 * p + ($urandom() % 120));
            plen[p] = (p == 0) ? 0 : (p == 1) ? 3 : int'($urandom() % 4);
            for (int s = 0; s < 4; s++) pw[p][s] = rand_word();
            load_prog(p);
        end
        // R6: two captures of res0 at different steps, last one wins
        plen[2] = 2;
        pw[2][0][61:58] = 4'b0010; pw[2][1][61:58] = 4'b1011; pw[2][2][61:58] = 4'b0000;
        load_prog(2);
        // R7: no captures at all
        plen[3] = 1;
        pw[3][0][61:58] = 4'b0000; pw[3][1][61:58] = 4'b0000;
        load_prog(3);

        run_ci(0, 2'd0, 0);   // R3 one-step instruction, all registers
        run_ci(1, 2'd3, 0);   // R3 four-step instruction, entry 1023
        run_ci(2, 2'd2, 0);   // R6 overwrite
        run_ci(3, 2'd1, 0);   // R7 flags cleared
        run_ci(1, 2'd1, 1);   // R8 start while running
        run_ci(0, 2'd2, 1);   // R8 start during one-step run
        for (int n = 0; n < 300; n++) begin
            if (n % 50 == 49) begin
                int q = 4 + int'($urandom() % 4);
                plen[q] = int'($urandom() % 4);
                for (int s = 0; s < 4; s++) pw[q][s] = rand_word();
                load_prog(q);
            end
            run_ci(int'($urandom() % 8), 2'($urandom()), bit'($urandom() % 4 == 0));
        end
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            vectors++;
            fails++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule